// File: doc/BRIEF.md
# Three-wire serial register programming port

This block receives control words over a slow, write-only, three-line serial link (data, clock, enable) and stores them in a bank of seven 16-bit registers whose contents are presented in parallel to the rest of the chip. All three serial lines are asynchronous to the system clock. They pass through synchronizers and are oversampled, so the system clock must run at least four times faster than the serial clock.

A frame is delimited by the enable line. Enable goes low, then 19 bits are shifted in on falling serial-clock edges. The 16-bit data word comes first, most significant bit first, and the 3-bit register address follows it. Enable then rises. If exactly 19 bits were counted, the frame is loaded; any other count discards it. The three low-numbered words hold divider ratios and are double-buffered. A load only updates their shadow copy. A following enable pulse with no clock edges copies every shadow to its active copy, and further such pulses only re-apply the same values. The remaining words take a loaded value at once.

Top module: `serprog_regbank`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `reg_q` is all zero and `wr_stb`, `apply_stb` and `hold_err` are low.
- R2: The first bit of a frame is data bit 15 and the 19th is address bit 0, so the data word occupies the leading 16 bits and the address the trailing 3. Word n occupies `reg_q[16*n+15:16*n]`.
- R3: A bit is sampled from `ser_data` only on a falling edge of `ser_clk` while `ser_en` is low. The value on `ser_data` after the rising edge has no effect.
- R4: An enable rising edge after 18 or 20 (any count other than 0 or 19) bits discards the frame: no register changes and no strobe is issued.
- R5: A frame with address 7 is accepted but writes nothing. No strobe is issued and `reg_q` is unchanged.
- R6: A loaded frame for word 0, 1 or 2 leaves `reg_q` unchanged. The next enable rising edge with zero bits counted copies all three shadows to `reg_q` and pulses `apply_stb` for one cycle.
- R7: A loaded frame for word 3, 4, 5 or 6 appears on `reg_q` right after the enable rising edge.
- R8: An enable pulse without clock edges changes no stored content. It only re-applies the shadows that are already loaded, and `reg_q` changes only in a cycle where `wr_stb` or `apply_stb` is high.
- R9: Every load of words 0 to 6 pulses `wr_stb` for exactly one cycle, with that address on `wr_addr`.
- R10: A falling `ser_clk` edge within `HOLD_CYC` system cycles of an enable rising edge pulses `hold_err` for one cycle and is not shifted in.
- R11: A falling edge of `ser_en` clears the bit counter, so a partial frame followed by a new enable-low phase and 19 bits loads correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Serial clock line, idle high, asynchronous |
| ser_en | input | 1 | Frame enable line, active low while shifting, asynchronous |
| reg_q | output | 112 | Active contents of the seven 16-bit words |
| wr_stb | output | 1 | One-cycle pulse when a frame is loaded |
| wr_addr | output | 3 | Address of the loaded word, valid with `wr_stb` |
| apply_stb | output | 1 | One-cycle pulse when shadows are copied to the active words |
| hold_err | output | 1 | One-cycle pulse on a serial clock edge inside the hold window |

## Verification
The hardest condition to reach from the ports is a serial clock edge inside the hold window while enable is already low again. The edge then lands in a live shifting phase and would corrupt the next frame if it were counted. The stimulus raises enable to load a frame, drops it two system cycles later, and makes one falling clock edge on the next cycle. It then sends a full 19-bit frame and checks that this frame loads intact and that exactly one `hold_err` pulse was seen. Falling-edge capture is exercised by flipping the data line right after every rising clock edge.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  // Outcome of an enable rising edge, decided from the bit count
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LOAD  = 2'd1,
    EV_APPLY = 2'd2,
    EV_DROP  = 2'd3
  } en_event_e;
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      q_prev <= RST_VAL;
    end else begin
      chain[0] <= d_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      q_prev <= chain[STAGES-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serprog_shifter.sv
module serprog_shifter
  import serprog_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int HOLD_CYC = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdat,
  input  logic              sclk_fall,
  input  logic              en_lvl,
  input  logic              en_rise,
  input  logic              en_fall,
  output en_event_e         ev,
  output logic [DATA_W-1:0] f_data,
  output logic [ADDR_W-1:0] f_addr,
  output logic              hold_err
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int HC_W    = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [HC_W-1:0]    hold_cnt;
  logic               in_hold;
  logic               take;

  assign in_hold = (hold_cnt != '0);
  assign take    = sclk_fall && !en_lvl && !in_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      cnt      <= '0;
      hold_cnt <= '0;
      hold_err <= 1'b0;
    end else begin
      hold_err <= sclk_fall && in_hold;
      if (en_rise)      hold_cnt <= HC_W'(HOLD_CYC);
      else if (in_hold) hold_cnt <= hold_cnt - 1'b1;

      if (take) shreg <= {shreg[FRAME_W-2:0], sdat};

      if (en_fall)                  cnt <= '0;
      else if (take && cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    ev = EV_NONE;
    if (en_rise) begin
      if (cnt == CNT_FULL)  ev = EV_LOAD;
      else if (cnt == '0)   ev = EV_APPLY;
      else                  ev = EV_DROP;
    end
  end

  assign f_data = shreg[FRAME_W-1:ADDR_W];
  assign f_addr = shreg[ADDR_W-1:0];
endmodule

// File: rtl/serprog_bank.sv
module serprog_bank
  import serprog_pkg::*;
#(
  parameter int                  DATA_W   = 16,
  parameter int                  ADDR_W   = 3,
  parameter int                  NUM_REGS = 7,
  parameter logic [NUM_REGS-1:0] DIV_MASK = 7'b0000111
) (
  input  logic                       clk,
  input  logic                       rst,
  input  en_event_e                  ev,
  input  logic [DATA_W-1:0]          f_data,
  input  logic [ADDR_W-1:0]          f_addr,
  output logic [NUM_REGS*DATA_W-1:0] reg_q,
  output logic                       wr_stb,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic                       apply_stb
);
  logic load;
  logic apply;

  assign load  = (ev == EV_LOAD) && (int'(f_addr) < NUM_REGS);
  assign apply = (ev == EV_APPLY);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic sel;
    logic [DATA_W-1:0] active;
    assign sel = load && (f_addr == ADDR_W'(g));

    if (DIV_MASK[g]) begin : g_dbuf
      logic [DATA_W-1:0] shadow;
      always_ff @(posedge clk) begin
        if (rst) begin
          shadow <= '0;
          active <= '0;
        end else begin
          if (sel)   shadow <= f_data;
          if (apply) active <= shadow;
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst)      active <= '0;
        else if (sel) active <= f_data;
      end
    end

    assign reg_q[g*DATA_W +: DATA_W] = active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      apply_stb <= 1'b0;
    end else begin
      wr_stb    <= load;
      apply_stb <= apply;
      if (load) wr_addr <= f_addr;
    end
  end
endmodule

// File: rtl/serprog_regbank.sv
module serprog_regbank
  import serprog_pkg::*;
#(
  parameter int                  DATA_W   = 16,
  parameter int                  ADDR_W   = 3,
  parameter int                  NUM_REGS = 7,
  parameter logic [NUM_REGS-1:0] DIV_MASK = 7'b0000111,
  parameter int                  HOLD_CYC = 7,
  parameter int                  SYNC_STG = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ser_data,
  input  logic                       ser_clk,
  input  logic                       ser_en,
  output logic [NUM_REGS*DATA_W-1:0] reg_q,
  output logic                       wr_stb,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic                       apply_stb,
  output logic                       hold_err
);
  // bit order in the synchronizer: {en, clk, data}; en and clk idle high
  localparam logic [2:0] LINE_IDLE = 3'b110;

  logic [2:0] s_now;
  logic [2:0] s_prev;
  logic       sclk_fall;
  logic       en_rise;
  logic       en_fall;
  en_event_e  ev;
  logic [DATA_W-1:0] f_data;
  logic [ADDR_W-1:0] f_addr;

  serprog_sync #(
    .W       (3),
    .STAGES  (SYNC_STG),
    .RST_VAL (LINE_IDLE)
  ) i_sync (
    .clk    (clk),
    .rst    (rst),
    .d_in   ({ser_en, ser_clk, ser_data}),
    .q      (s_now),
    .q_prev (s_prev)
  );

  assign sclk_fall = s_prev[1] && !s_now[1];
  assign en_rise   = !s_prev[2] && s_now[2];
  assign en_fall   = s_prev[2] && !s_now[2];

  serprog_shifter #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .HOLD_CYC (HOLD_CYC)
  ) i_shift (
    .clk       (clk),
    .rst       (rst),
    .sdat      (s_now[0]),
    .sclk_fall (sclk_fall),
    .en_lvl    (s_now[2]),
    .en_rise   (en_rise),
    .en_fall   (en_fall),
    .ev        (ev),
    .f_data    (f_data),
    .f_addr    (f_addr),
    .hold_err  (hold_err)
  );

  serprog_bank #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .DIV_MASK (DIV_MASK)
  ) i_bank (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .f_data    (f_data),
    .f_addr    (f_addr),
    .reg_q     (reg_q),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .apply_stb (apply_stb)
  );
endmodule

// File: rtl/serprog_checker.sv
module serprog_checker #(
  parameter int QW       = 112,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [QW-1:0]     reg_q,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              apply_stb,
  input logic              hold_err
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (reg_q == '0 && !wr_stb && !apply_stb && !hold_err)); // R1

  AST_ADDR_MAPPED: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (int'(wr_addr) < NUM_REGS)); // R5

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R9

  AST_APPLY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && apply_stb)); // R6

  AST_CHANGE_STROBED: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_q) |-> (wr_stb || apply_stb)); // R8

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    hold_err |=> !hold_err); // R10
endmodule

bind serprog_regbank serprog_checker #(
  .QW       (NUM_REGS*DATA_W),
  .ADDR_W   (ADDR_W),
  .NUM_REGS (NUM_REGS)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_q     (reg_q),
  .wr_stb    (wr_stb),
  .wr_addr   (wr_addr),
  .apply_stb (apply_stb),
  .hold_err  (hold_err)
);

// File: tb/test_serprog_regbank.sv
`timescale 1ns/1ps
module test_serprog_regbank;
  localparam int H = 8; // system cycles per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_data = 1'b0;
  logic ser_clk  = 1'b1;
  logic ser_en   = 1'b1;
  logic [111:0] reg_q;
  logic wr_stb, apply_stb, hold_err;
  logic [2:0] wr_addr;

  int tests = 0;
  int fails = 0;
  int n_wr = 0, n_apply = 0, n_err = 0;
  logic [2:0] last_addr = '0;
  logic [15:0] model [7];

  always #4 clk = ~clk;

  serprog_regbank i_serprog_regbank (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_en(ser_en),
    .reg_q(reg_q), .wr_stb(wr_stb), .wr_addr(wr_addr), .apply_stb(apply_stb),
    .hold_err(hold_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin n_wr++; last_addr = wr_addr; end
      if (apply_stb) n_apply++;
      if (hold_err) n_err++;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [111:0] model_q();
    logic [111:0] v;
    for (int i = 0; i < 7; i++) v[i*16 +: 16] = model[i];
    return v;
  endfunction

  // shift n bits, MSB of the low n first; data flips after each rising edge (R3)
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      cyc(H);
      ser_clk = 1'b0;
      cyc(H);
      ser_clk = 1'b1;
      cyc(1);
      ser_data = ~v[i];
      cyc(H - 1);
    end
  endtask

  task automatic frame_n(input logic [31:0] v, input int n);
    ser_en = 1'b0;
    cyc(H);
    send_bits(v, n);
    ser_en = 1'b1;
    cyc(12);
  endtask

  task automatic en_pulse();
    ser_en = 1'b0;
    cyc(H);
    ser_en = 1'b1;
    cyc(12);
  endtask

  function automatic logic [31:0] fr(input logic [2:0] a, input logic [15:0] d);
    return {13'b0, d, a};
  endfunction

  // {address, data}
  localparam logic [18:0] VEC [7] = '{
    {3'd0, 16'h1234}, {3'd3, 16'hABCD}, {3'd1, 16'hFFFF}, {3'd6, 16'h8001},
    {3'd2, 16'h5A5A}, {3'd4, 16'h0F0F}, {3'd5, 16'h7FFE}
  };

  logic [15:0] shadow_m [3];

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) model[i] = '0;
    for (int i = 0; i < 3; i++) shadow_m[i] = '0;
    cyc(5);
    chk("R1 reg_q in reset", reg_q, '0);
    rst = 1'b0;
    cyc(1);
    chk("R1 strobes after reset", {wr_stb, apply_stb, hold_err}, 3'b000);
    chk("R1 reg_q after reset", reg_q, '0);

    // table walk: R2 R6 R7 R9
    for (int k = 0; k < 7; k++) begin
      logic [2:0]  a;
      logic [15:0] d;
      a = VEC[k][18:16];
      d = VEC[k][15:0];
      n_wr = 0; n_apply = 0;
      frame_n(fr(a, d), 19);
      chk("R9 one wr_stb per load", n_wr, 1);
      chk("R9 wr_addr", last_addr, a);
      if (a < 3) begin
        shadow_m[a] = d;
        chk("R6 divider word held before apply", reg_q, model_q());
        en_pulse();
        for (int i = 0; i < 3; i++) model[i] = shadow_m[i];
        chk("R6 apply_stb pulse", n_apply, 1);
        chk("R2 R6 divider word after apply", reg_q, model_q());
      end else begin
        model[a] = d;
        chk("R2 R7 direct word loaded", reg_q, model_q());
      end
    end

    // R4: 18 and 20 bit frames dropped
    n_wr = 0; n_apply = 0;
    frame_n(fr(3'd3, 16'h1111) >> 1, 18);
    chk("R4 18-bit frame dropped", reg_q, model_q());
    frame_n({fr(3'd4, 16'h2222), 1'b1}, 20);
    chk("R4 20-bit frame dropped", reg_q, model_q());
    chk("R4 no strobes", {n_wr, n_apply}, 64'd0);

    // R5: address 7
    frame_n(fr(3'd7, 16'hDEAD), 19);
    chk("R5 address 7 no strobe", n_wr, 0);
    chk("R5 address 7 no change", reg_q, model_q());

    // R8: extra enable pulses only re-apply
    frame_n(fr(3'd1, 16'h0BAD), 19);
    shadow_m[1] = 16'h0BAD;
    en_pulse();
    model[1] = 16'h0BAD;
    n_wr = 0; n_apply = 0;
    en_pulse();
    en_pulse();
    chk("R8 repeat apply keeps content", reg_q, model_q());
    chk("R8 repeat apply strobes", {n_wr, n_apply}, {32'd0, 32'd2});

    // R11: partial frame then restart
    ser_en = 1'b0;
    cyc(H);
    send_bits(32'h5, 5);
    ser_en = 1'b1;
    cyc(4);
    frame_n(fr(3'd6, 16'hC3C3), 19);
    model[6] = 16'hC3C3;
    chk("R11 counter cleared by enable fall", reg_q, model_q());

    // R10: clock edge inside hold window
    n_err = 0;
    ser_en = 1'b0;
    cyc(H);
    send_bits(fr(3'd4, 16'h4444), 19);
    model[4] = 16'h4444;
    ser_en = 1'b1;
    cyc(2);
    ser_en = 1'b0;
    cyc(1);
    ser_data = 1'b1;
    ser_clk = 1'b0;
    cyc(H);
    ser_clk = 1'b1;
    cyc(H);
    send_bits(fr(3'd5, 16'h9A9A), 19);
    ser_en = 1'b1;
    cyc(12);
    model[5] = 16'h9A9A;
    chk("R10 hold_err pulses", n_err, 1);
    chk("R10 edge in hold window not shifted", reg_q, model_q());

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule